// File: doc/BRIEF.md
# AES3 Channel Status Block Position Tracker

This block follows where an AES3 transmitter stands inside the 192-frame channel status block. It counts frames and the two subframes of each frame, advancing on a one-cycle subframe strobe from the transmit sequencer. It publishes the frame index and the subframe half that the transmitter is now sending. A block-start line has a pad-style split into a data-in, a data-out and an output enable. With the direction select in output mode, the block drives that line high across the opening subframe of every block. In input mode the block only listens. A level held high there for enough master-clock cycles re-anchors the count, so the next subframe opens a new block.

Serial channel-status and validity bits come in beside the audio and are sampled on the rising edge of the output word clock. They are handed to the transmitter when the frame's first subframe starts and stay fixed through its second subframe. Both halves of a frame therefore carry the same pair of bits, together with the frame index they belong to. Biphase coding, preambles, parity and the line driver belong to other blocks.

Top module: `aes3_csblk_track`

## Requirements
- R1: While `rst` is high at a clock edge, that edge sets `blk_out_o`, `blk_oe_o`, `c_bit_o` and `v_bit_o` to 0, `frame_idx_o` to FRAMES-1 and `sub_o` to 1, so the first strobe after reset opens frame 0.
- R2: Each cycle with `subfr_stb_i` high moves the position one subframe ahead at that edge. `sub_o` encodes 0 for the first subframe of a frame and 1 for the second. After a second subframe the frame index goes up by one. Without a strobe the position holds.
- R3: The strobe that follows frame FRAMES-1, second subframe, leads to frame 0, first subframe.
- R4: `blk_out_o` is high exactly while the position is frame 0, first subframe. It rises at the edge of the strobe that enters that subframe and falls at the edge of the next strobe.
- R5: `blk_oe_o` follows `blk_dir_i` (1 = output mode) one cycle later. In input mode the block never enables its driver.
- R6: In input mode, when `blk_in_i` is high at MIN_HOLD consecutive clock edges, a pending start is armed. The next strobe after arming goes to frame 0, first subframe, from whatever position the count was in.
- R7: In input mode, a high level on `blk_in_i` lasting fewer than MIN_HOLD edges leaves the count untouched.
- R8: In output mode, `blk_in_i` has no effect on the position.
- R9: One unbroken high level on `blk_in_i` arms at most one forced start, however long it lasts.
- R10: On each rising edge of `word_clk_i`, `c_ser_i` and `v_ser_i` are captured. The strobe that enters a first subframe presents the last captured pair on `c_bit_o`/`v_bit_o`. The strobe that enters a second subframe leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| word_clk_i | input | 1 | Output word clock; its rising edge samples C and V |
| subfr_stb_i | input | 1 | One-cycle pulse marking the start of a subframe |
| c_ser_i | input | 1 | Serial channel-status bit input |
| v_ser_i | input | 1 | Serial validity bit input |
| blk_dir_i | input | 1 | Block-start direction: 1 output mode, 0 input mode |
| blk_in_i | input | 1 | Block-start line as seen at the pad |
| blk_out_o | output | 1 | Block-start value the block would drive |
| blk_oe_o | output | 1 | Driver enable for the block-start pad |
| frame_idx_o | output | $clog2(FRAMES) | Frame index inside the channel status block |
| sub_o | output | 1 | Subframe half: 0 first, 1 second |
| c_bit_o | output | 1 | Channel-status bit for the current frame |
| v_bit_o | output | 1 | Validity bit for the current frame |

## Verification
The bench builds the block with its defaults, FRAMES = 192 and MIN_HOLD = 3. A block of 384 subframes at about a dozen master clocks each takes only a few thousand cycles, so the natural wrap from 191 to 0 is walked completely rather than reached by a shortened count. With a three-cycle threshold, pulses of two, three and many cycles fall on both sides of the arming limit. Forced starts are placed both from a first and from a second subframe in mid-block.

// File: rtl/aes3_csblk_pkg.sv
package aes3_csblk_pkg;
  typedef enum logic {
    SUB_FIRST  = 1'b0,
    SUB_SECOND = 1'b1
  } sub_half_e;

  function automatic int unsigned frame_width(input int unsigned frames);
    return (frames < 2) ? 1 : $clog2(frames);
  endfunction
endpackage

// File: rtl/aes3_start_qual.sv
module aes3_start_qual #(
  parameter int unsigned MIN_HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic listen_i,
  input  logic level_i,
  input  logic consume_i,
  output logic arm_o
);
  localparam int unsigned CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] SAT     = CW'(MIN_HOLD);
  localparam logic [CW-1:0] ARM_AT  = CW'(MIN_HOLD - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !listen_i || !level_i) begin
      run_q <= '0;
    end else if (run_q != SAT) begin
      run_q <= run_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !listen_i) begin
      arm_o <= 1'b0;
    end else if (level_i && run_q == ARM_AT) begin
      arm_o <= 1'b1;
    end else if (consume_i) begin
      arm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/aes3_frame_pos.sv
module aes3_frame_pos
  import aes3_csblk_pkg::*;
#(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned FW     = frame_width(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          force_i,
  output logic [FW-1:0] frame_o,
  output sub_half_e     half_o,
  output logic          at_start_o
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic to_start;
  assign to_start = force_i || (half_o == SUB_SECOND && frame_o == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_o    <= LAST;
      half_o     <= SUB_SECOND;
      at_start_o <= 1'b0;
    end else if (step_i) begin
      if (to_start) begin
        frame_o    <= '0;
        half_o     <= SUB_FIRST;
        at_start_o <= 1'b1;
      end else if (half_o == SUB_SECOND) begin
        frame_o    <= frame_o + FW'(1);
        half_o     <= SUB_FIRST;
        at_start_o <= 1'b0;
      end else begin
        half_o     <= SUB_SECOND;
        at_start_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aes3_cv_capture.sv
module aes3_cv_capture (
  input  logic clk,
  input  logic rst,
  input  logic wclk_i,
  input  logic c_i,
  input  logic v_i,
  input  logic present_i,
  output logic c_o,
  output logic v_o
);
  logic wclk_q;
  logic c_hold, v_hold;
  logic wclk_rise;

  assign wclk_rise = wclk_i && !wclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q <= 1'b1;
      c_hold <= 1'b0;
      v_hold <= 1'b0;
      c_o    <= 1'b0;
      v_o    <= 1'b0;
    end else begin
      wclk_q <= wclk_i;
      if (wclk_rise) begin
        c_hold <= c_i;
        v_hold <= v_i;
      end
      if (present_i) begin
        c_o <= c_hold;
        v_o <= v_hold;
      end
    end
  end
endmodule

// File: rtl/aes3_csblk_track.sv
module aes3_csblk_track
  import aes3_csblk_pkg::*;
#(
  parameter int unsigned FRAMES   = 192,
  parameter int unsigned MIN_HOLD = 3,
  localparam int unsigned FW      = frame_width(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_clk_i,
  input  logic          subfr_stb_i,
  input  logic          c_ser_i,
  input  logic          v_ser_i,
  input  logic          blk_dir_i,
  input  logic          blk_in_i,
  output logic          blk_out_o,
  output logic          blk_oe_o,
  output logic [FW-1:0] frame_idx_o,
  output logic          sub_o,
  output logic          c_bit_o,
  output logic          v_bit_o
);
  logic      force_arm;
  sub_half_e half;
  logic      enter_first;

  aes3_start_qual #(.MIN_HOLD(MIN_HOLD)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .listen_i  (!blk_dir_i),
    .level_i   (blk_in_i),
    .consume_i (subfr_stb_i),
    .arm_o     (force_arm)
  );

  aes3_frame_pos #(.FRAMES(FRAMES), .FW(FW)) u_pos (
    .clk        (clk),
    .rst        (rst),
    .step_i     (subfr_stb_i),
    .force_i    (force_arm),
    .frame_o    (frame_idx_o),
    .half_o     (half),
    .at_start_o (blk_out_o)
  );

  assign sub_o       = half;
  assign enter_first = subfr_stb_i && (force_arm || half == SUB_SECOND);

  aes3_cv_capture u_cv (
    .clk       (clk),
    .rst       (rst),
    .wclk_i    (word_clk_i),
    .c_i       (c_ser_i),
    .v_i       (v_ser_i),
    .present_i (enter_first),
    .c_o       (c_bit_o),
    .v_o       (v_bit_o)
  );

  always_ff @(posedge clk) begin
    if (rst) blk_oe_o <= 1'b0;
    else     blk_oe_o <= blk_dir_i;
  end
endmodule

// File: rtl/aes3_csblk_chk.sv
module aes3_csblk_chk #(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned FW     = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          stb,
  input logic          dir,
  input logic          blk_out,
  input logic          oe,
  input logic [FW-1:0] frame,
  input logic          sub,
  input logic          c_bit,
  input logic          v_bit,
  input logic          arm
);
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |=> (!blk_out && !oe && !c_bit && !v_bit));

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(frame) && $stable(sub)));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (stb && sub && frame == LAST) |=> (frame == '0 && !sub));

  assert_start_only_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    blk_out |-> (frame == '0 && !sub));

  assert_no_drive_listening_R5: assert property (@(posedge clk) disable iff (rst)
    !dir |=> !oe);

  assert_forced_lands_R6: assert property (@(posedge clk) disable iff (rst)
    (arm && stb) |=> (frame == '0 && !sub && blk_out));

  assert_cv_steady_second_R10: assert property (@(posedge clk) disable iff (rst)
    (stb && !sub && !arm) |=> ($stable(c_bit) && $stable(v_bit)));
endmodule

bind aes3_csblk_track aes3_csblk_chk #(.FRAMES(FRAMES), .FW(FW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .stb     (subfr_stb_i),
  .dir     (blk_dir_i),
  .blk_out (blk_out_o),
  .oe      (blk_oe_o),
  .frame   (frame_idx_o),
  .sub     (sub_o),
  .c_bit   (c_bit_o),
  .v_bit   (v_bit_o),
  .arm     (force_arm)
);

// File: tb/tb_aes3_csblk_track.sv
`timescale 1ns/1ps
module tb_aes3_csblk_track;
  localparam int FRAMES   = 192;
  localparam int MIN_HOLD = 3;
  localparam int FW       = $clog2(FRAMES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_clk_i = 1'b0, subfr_stb_i = 1'b0, c_ser_i = 1'b0, v_ser_i = 1'b0;
  logic blk_dir_i = 1'b1, blk_in_i = 1'b0;
  logic blk_out_o, blk_oe_o, sub_o, c_bit_o, v_bit_o;
  logic [FW-1:0] frame_idx_o;

  always #5 clk = ~clk;

  aes3_csblk_track #(.FRAMES(FRAMES), .MIN_HOLD(MIN_HOLD)) dut (
    .clk(clk), .rst(rst), .word_clk_i(word_clk_i), .subfr_stb_i(subfr_stb_i),
    .c_ser_i(c_ser_i), .v_ser_i(v_ser_i), .blk_dir_i(blk_dir_i), .blk_in_i(blk_in_i),
    .blk_out_o(blk_out_o), .blk_oe_o(blk_oe_o), .frame_idx_o(frame_idx_o),
    .sub_o(sub_o), .c_bit_o(c_bit_o), .v_bit_o(v_bit_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int exp_f = FRAMES - 1;
  int exp_s = 1;
  bit exp_force = 0;
  bit exp_c = 0, exp_v = 0;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One subframe: picks first or second half from the model.
  task automatic step(input bit c, input bit v, input string pos_tag);
    bit first;
    bit forced;
    forced = exp_force;
    first  = exp_force || (exp_s == 1);
    if (first) begin
      @(negedge clk); word_clk_i = 1'b0;
      @(negedge clk); word_clk_i = 1'b1; c_ser_i = c; v_ser_i = v;
      idle(2);
    end else begin
      @(negedge clk); word_clk_i = 1'b0; c_ser_i = ~c_ser_i; v_ser_i = ~v_ser_i;
      idle(2);
    end
    @(negedge clk); subfr_stb_i = 1'b1;
    @(negedge clk); subfr_stb_i = 1'b0;
    if (forced) begin
      exp_f = 0; exp_s = 0; exp_force = 0;
    end else if (exp_s == 1) begin
      exp_f = (exp_f == FRAMES - 1) ? 0 : exp_f + 1; exp_s = 0;
    end else begin
      exp_s = 1;
    end
    if (first) begin exp_c = c; exp_v = v; end
    check(forced ? "R6 frame" : {pos_tag, " frame"}, int'(frame_idx_o), exp_f);
    check(forced ? "R6 sub"   : {pos_tag, " sub"},   int'(sub_o), exp_s);
    check("R10 c bit", int'(c_bit_o), int'(exp_c));
    check("R10 v bit", int'(v_bit_o), int'(exp_v));
    if (blk_dir_i)
      check("R4 block start", int'(blk_out_o), int'(exp_f == 0 && exp_s == 0));
    idle(2);
  endtask

  task automatic pulse_in(input int cycles);
    @(negedge clk); blk_in_i = 1'b1;
    idle(cycles);
    blk_in_i = 1'b0;
    idle(1);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idle(3);
    check("R1 blk_out", int'(blk_out_o), 0);
    check("R1 oe", int'(blk_oe_o), 0);
    check("R1 c", int'(c_bit_o), 0);
    check("R1 v", int'(v_bit_o), 0);
    check("R1 frame", int'(frame_idx_o), FRAMES - 1);
    check("R1 sub", int'(sub_o), 1);
    rst = 1'b0;
    idle(2);
    check("R5 oe output mode", int'(blk_oe_o), 1);
  endtask

  task automatic t_output_seq;
    int f0;
    f0 = exp_f;
    for (int i = 0; i < 8; i++) step(i[0], i[1], "R2");
    check("R2 frames advanced", int'(frame_idx_o), (f0 + 4) % FRAMES);
    idle(4);
    check("R2 hold without strobe", int'(frame_idx_o), exp_f);
  endtask

  task automatic t_wrap;
    int guard = 0;
    while (!(exp_f == FRAMES - 1 && exp_s == 1) && guard < 2 * FRAMES + 4) begin
      step(exp_f[0], exp_f[2], "R2");
      guard++;
    end
    step(1'b1, 1'b0, "R3");
    check("R3 wrapped to zero", int'(frame_idx_o), 0);
    check("R3 start flag after wrap", int'(blk_out_o), 1);
    step(1'b0, 1'b1, "R3");
    check("R4 start falls on second half", int'(blk_out_o), 0);
  endtask

  task automatic t_force;
    @(negedge clk); blk_dir_i = 1'b0;
    idle(2);
    check("R5 oe input mode", int'(blk_oe_o), 0);
    while (!(exp_f == 7 && exp_s == 0)) step(1'b0, 1'b1, "R2");
    pulse_in(MIN_HOLD);
    exp_force = 1;
    step(1'b1, 1'b1, "R6");
    check("R6 landed from first half", int'(frame_idx_o) * 2 + int'(sub_o), 0);
    while (!(exp_f == 3 && exp_s == 1)) step(1'b1, 1'b0, "R2");
    pulse_in(MIN_HOLD);
    exp_force = 1;
    step(1'b0, 1'b0, "R6");
    check("R6 landed from second half", int'(frame_idx_o) * 2 + int'(sub_o), 0);
    check("R5 still undriven", int'(blk_oe_o), 0);
  endtask

  task automatic t_short;
    step(1'b1, 1'b1, "R2");
    pulse_in(MIN_HOLD - 1);
    step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b0, "R7");
    check("R7 short pulse ignored", int'(frame_idx_o), exp_f);
  endtask

  task automatic t_long;
    while (!(exp_f == 5 && exp_s == 1)) step(1'b0, 1'b0, "R2");
    @(negedge clk); blk_in_i = 1'b1;
    idle(MIN_HOLD + 2);
    exp_force = 1;
    step(1'b1, 1'b0, "R9");
    step(1'b0, 1'b1, "R9");
    step(1'b1, 1'b1, "R9");
    check("R9 single arm per level", int'(frame_idx_o), 1);
    @(negedge clk); blk_in_i = 1'b0;
    idle(1);
  endtask

  task automatic t_out_force;
    @(negedge clk); blk_dir_i = 1'b1;
    idle(2);
    check("R5 oe back on", int'(blk_oe_o), 1);
    pulse_in(MIN_HOLD + 2);
    step(1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    check("R8 pad ignored in output mode", int'(frame_idx_o), exp_f);
    check("R8 not at block start", int'(blk_out_o), 0);
  endtask

  initial begin
    t_reset();
    t_output_seq();
    t_wrap();
    t_force();
    t_short();
    t_long();
    t_out_force();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule